// File: doc/BRIEF.md
# Buffered Down-Counting PWM Timer

This block holds five timer channels. Each channel has a down-counter that steps once per strobe on its own tick input. Software writes a reload value and a compare value into buffer registers. A channel takes those values into its active counter and comparator only when software holds the channel's manual-update bit, or when auto-reload is enabled and the counter finishes a period. A single control word carries the run, manual-update, polarity and auto-reload bits for all channels.

Channels 0 to 3 each drive a waveform output. Channel 4 has no output and serves only as an interval timer. Every channel gives a one-clock expiry pulse at the end of each period, which lets a system count periods or schedule work. The tick strobes come from clock logic outside the block. Interrupt collection is also done outside the block.

Top module: `bufpwm_timer`

## Requirements
- R1: Channel n has a reload buffer at byte address 0x0C+12n and a compare buffer at 0x10+12n. Each buffer keeps the low CW bits of a write and reads back zero-extended. An address that maps to no register reads as zero.
- R2: The control word sits at address 0x08 and reads as zero after reset. Channel 0 owns bits 3:0 of it. Channel n≥1 owns the four bits starting at bit 4(n+1). Bits 7:4 and all bits that belong to no field never store a 1, so with NCH=5 a write of all ones reads back 0x007FFF0F.
- R3: Writing a buffer changes neither the active counter nor the output until the next load.
- R4: Field bit 1 is manual update. On every clock edge where it is set, the channel copies both buffers into its active registers and does not count.
- R5: Field bit 0 is start. While start is set, each tick strobe lowers the counter by one. A period lasts reload+1 ticks.
- R6: With polarity bit clear, an output reads 0 while the counter is above the active compare and 1 once the counter is at or below it. A compare of all ones keeps the output at 0 for the whole period.
- R7: Field bit 2 on channels 0 to 3 inverts that channel's output.
- R8: A tick that arrives while a running counter is at zero ends the period. The channel's expiry output is then 1 for the next clock only.
- R9: Field bit 3 (bit 2 on the last channel) is auto-reload. When it is set, the end of a period loads both buffers into the active registers.
- R10: When auto-reload is clear, the channel stops at the end of a period. Later ticks then give no expiry, and the output rests at its idle level until a manual update restarts the channel.
- R11: While start is clear, the counter is frozen and the output sits at its idle level, which equals the polarity bit. Setting start again resumes counting from the frozen value.
- R12: The last channel uses control bit 20 for start, bit 21 for manual update and bit 22 for auto-reload. It has no waveform output but still counts and pulses expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | NCH | Per-channel count strobes |
| wr_en | input | 1 | Register write enable |
| addr | input | AW | Byte address for reads and writes |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for addr (combinational) |
| pwm_out | output | NCH-1 | Waveform outputs of channels 0 to NCH-2 |
| expire | output | NCH | One-clock end-of-period pulses |

## Verification
The waveform path is driven with a reload of 4 and a compare of 1. The test confirms where the output goes high inside the period and the tick on which expiry occurs. It also confirms that a reload value written in the middle of a period only appears after the wrap.

An all-ones compare and a held manual-update bit separate a design that compares by magnitude from one that treats full duty as a special case. They also separate a design that counts during a load from one that does not. One-shot runs, freezing with start cleared and the auto-reload bit moved on the last channel separate stopping from pausing, and separate the irregular control field layout from the regular one.

// File: rtl/bufpwm_timer.sv
module bufpwm_timer #(
  parameter int NCH = 5,
  parameter int CW  = 16,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] tick,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic [NCH-2:0] pwm_out,
  output logic [NCH-1:0] expire
);

  function automatic int nib(input int n);
    return (n == 0) ? 0 : 4 * (n + 1);
  endfunction

  function automatic int arbit(input int n);
    return nib(n) + ((n == NCH - 1) ? 2 : 3);
  endfunction

  function automatic logic [DW-1:0] ctrl_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int n = 0; n < NCH; n++) begin
      m[nib(n)]     = 1'b1;
      m[nib(n) + 1] = 1'b1;
      m[arbit(n)]   = 1'b1;
      if (n < NCH - 1) m[nib(n) + 2] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [DW-1:0] CMASK     = ctrl_mask();
  localparam logic [AW-1:0] CTRL_ADDR = AW'(8);

  logic [DW-1:0] ctrl_q;
  logic [CW-1:0] cntb_v [NCH];
  logic [CW-1:0] cmpb_v [NCH];
  logic [CW-1:0] cnt_v  [NCH];
  logic [CW-1:0] cmp_v  [NCH];
  logic [NCH-1:0] done_v;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl_q <= '0;
    else if (wr_en && addr == CTRL_ADDR) ctrl_q <= wdata & CMASK;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int P = nib(ch);
    localparam int A = arbit(ch);
    localparam logic [AW-1:0] CB = AW'(12 + 12 * ch);
    localparam logic [AW-1:0] MB = AW'(16 + 12 * ch);

    logic [CW-1:0] cb, mb, cnt, cmp;
    logic dn, ex, st, mu, ar;

    assign st = ctrl_q[P];
    assign mu = ctrl_q[P + 1];
    assign ar = ctrl_q[A];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cb <= '0;
        mb <= '0;
      end else if (wr_en) begin
        if (addr == CB) cb <= wdata[CW-1:0];
        if (addr == MB) mb <= wdata[CW-1:0];
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt <= '0;
        cmp <= '0;
        dn  <= 1'b0;
        ex  <= 1'b0;
      end else begin
        ex <= 1'b0;
        if (mu) begin
          cnt <= cb;
          cmp <= mb;
          dn  <= 1'b0;
        end else if (st && !dn && tick[ch]) begin
          if (cnt == '0) begin
            ex <= 1'b1;
            if (ar) begin
              cnt <= cb;
              cmp <= mb;
            end else begin
              dn <= 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end

    assign cntb_v[ch] = cb;
    assign cmpb_v[ch] = mb;
    assign cnt_v[ch]  = cnt;
    assign cmp_v[ch]  = cmp;
    assign done_v[ch] = dn;
    assign expire[ch] = ex;

    if (ch < NCH - 1) begin : g_out
      logic hi;
      assign hi = (cmp != '1) && (cnt <= cmp);
      assign pwm_out[ch] = (st & ~dn & hi) ^ ctrl_q[P + 2];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == CTRL_ADDR) rdata = ctrl_q;
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(12 + 12 * i)) rdata = DW'(cntb_v[i]);
      if (addr == AW'(16 + 12 * i)) rdata = DW'(cmpb_v[i]);
    end
  end

endmodule

module bufpwm_timer_chk #(
  parameter int NCH = 5,
  parameter int CW  = 16,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] tick,
  input logic [DW-1:0]  ctrl_q,
  input logic [CW-1:0]  cnt_v  [NCH],
  input logic [CW-1:0]  cmp_v  [NCH],
  input logic [CW-1:0]  cntb_v [NCH],
  input logic [CW-1:0]  cmpb_v [NCH],
  input logic [NCH-1:0] done_v,
  input logic [NCH-2:0] pwm_out,
  input logic [NCH-1:0] expire
);

  function automatic int nib(input int n);
    return (n == 0) ? 0 : 4 * (n + 1);
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_c
    localparam int P = nib(c);

    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[P + 1] |=> (cnt_v[c] == $past(cntb_v[c]) && cmp_v[c] == $past(cmpb_v[c]) && !done_v[c]));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick[c] && !ctrl_q[P + 1]) |=> cnt_v[c] == $past(cnt_v[c]));

    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[c] && ctrl_q[P] && !ctrl_q[P + 1] && !done_v[c] && cnt_v[c] != '0)
      |=> cnt_v[c] == ($past(cnt_v[c]) - CW'(1)));

    a_r8_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      expire[c] |-> ($past(tick[c]) && $past(cnt_v[c]) == '0));

    a_r10_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (done_v[c] && !ctrl_q[P + 1]) |=> !expire[c]);

    if (c < NCH - 1) begin : g_o
      a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[P] |-> pwm_out[c] == ctrl_q[P + 2]);

      a_r6_full: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[P] && !done_v[c] && cmp_v[c] == '1) |-> pwm_out[c] == ctrl_q[P + 2]);
    end
  end

endmodule

bind bufpwm_timer bufpwm_timer_chk #(.NCH(NCH), .CW(CW), .DW(DW)) u_chk (.*);

// File: tb/bufpwm_timer_test.sv
module bufpwm_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  tick = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm_out;
  logic [4:0]  expire;

  int n_chk = 0;
  int n_bad = 0;
  bit reported = 0;

  always #2 clk = ~clk;

  bufpwm_timer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out), .expire(expire)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic tk(input int ch);
    @(negedge clk);
    tick = 5'(1 << ch);
    @(negedge clk);
    tick = '0;
  endtask

  task automatic step(input string req, input int ch, input logic p, input logic e);
    tk(ch);
    if (ch < 4) check(req, 32'(pwm_out[ch]), 32'(p));
    check(req, 32'(expire[ch]), 32'(e));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h08, d);
    check("R2 reset ctrl", d, 0);
    check("R11 reset outputs", 32'(pwm_out), 0);
    check("R8 reset expire", 32'(expire), 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(8'h24, 32'h1234);
    rd(8'h24, d);
    check("R1 reload ch2", d, 32'h1234);
    wr(8'h40, 32'hABCDEF01);
    rd(8'h40, d);
    check("R1 compare ch4 width", d, 32'hEF01);
    rd(8'h44, d);
    check("R1 unmapped", d, 0);
    wr(8'h08, 32'hFFFFFFFF);
    rd(8'h08, d);
    check("R2 mask", d, 32'h007FFF0F);
    wr(8'h08, 32'h0);
  endtask

  task automatic t_wave();
    wr(8'h0C, 4);
    wr(8'h10, 1);
    wr(8'h08, 32'h2);
    wr(8'h08, 32'h9);
    check("R6 start level", 32'(pwm_out[0]), 0);
    step("R5 cnt3", 0, 0, 0);
    step("R5 cnt2", 0, 0, 0);
    wr(8'h0C, 2);
    step("R3 old period cnt1", 0, 1, 0);
    step("R6 cnt0", 0, 1, 0);
    step("R8 R9 wrap", 0, 0, 1);
    step("R3 new period cnt1", 0, 1, 0);
    step("R3 new period cnt0", 0, 1, 0);
    step("R9 second wrap", 0, 0, 1);
  endtask

  task automatic t_invert();
    wr(8'h08, 32'h2);
    wr(8'h08, 32'hD);
    check("R7 inverted cnt2", 32'(pwm_out[0]), 1);
    step("R7 inverted cnt1", 0, 0, 0);
    step("R7 inverted cnt0", 0, 0, 0);
    step("R7 inverted wrap", 0, 1, 1);
  endtask

  task automatic t_manual_full();
    wr(8'h18, 3);
    wr(8'h1C, 2);
    wr(8'h08, 32'h300);
    for (int i = 0; i < 3; i++) step("R4 no count while loading", 1, 0, 0);
    wr(8'h1C, 32'hFFFF);
    wr(8'h08, 32'h900);
    for (int i = 0; i < 3; i++) step("R6 full compare low", 1, 0, 0);
    step("R6 full compare wrap", 1, 0, 1);
    wr(8'h08, 32'hD00);
    check("R7 full compare inverted", 32'(pwm_out[1]), 1);
    step("R7 full compare inverted tick", 1, 1, 0);
  endtask

  task automatic t_oneshot();
    wr(8'h24, 2);
    wr(8'h28, 0);
    wr(8'h08, 32'h2000);
    wr(8'h08, 32'h1000);
    check("R10 start", 32'(pwm_out[2]), 0);
    step("R10 cnt1", 2, 0, 0);
    step("R10 cnt0", 2, 1, 0);
    step("R10 end", 2, 0, 1);
    step("R10 stopped", 2, 0, 0);
    step("R10 stopped again", 2, 0, 0);
    wr(8'h08, 32'h3000);
    wr(8'h08, 32'h1000);
    check("R10 restart", 32'(pwm_out[2]), 0);
    step("R10 restart cnt1", 2, 0, 0);
    step("R10 restart cnt0", 2, 1, 0);
  endtask

  task automatic t_pause();
    wr(8'h30, 3);
    wr(8'h34, 1);
    wr(8'h08, 32'h20000);
    wr(8'h08, 32'h90000);
    step("R11 cnt2", 3, 0, 0);
    step("R11 cnt1", 3, 1, 0);
    wr(8'h08, 32'h80000);
    check("R11 idle", 32'(pwm_out[3]), 0);
    for (int i = 0; i < 3; i++) step("R11 frozen", 3, 0, 0);
    wr(8'h08, 32'h90000);
    check("R11 resume cnt1", 32'(pwm_out[3]), 1);
    step("R11 resume cnt0", 3, 1, 0);
    step("R11 resume wrap", 3, 0, 1);
    wr(8'h08, 32'hC0000);
    check("R11 idle inverted", 32'(pwm_out[3]), 1);
  endtask

  task automatic t_last();
    wr(8'h3C, 1);
    wr(8'h40, 0);
    wr(8'h08, 32'h200000);
    wr(8'h08, 32'h500000);
    step("R12 cnt0", 4, 0, 0);
    step("R12 reload at bit 22", 4, 0, 1);
    step("R12 cnt0 again", 4, 0, 0);
    step("R12 second wrap", 4, 0, 1);
    wr(8'h08, 32'h100000);
    step("R12 one-shot cnt0", 4, 0, 0);
    step("R12 one-shot end", 4, 0, 1);
    step("R12 stopped", 4, 0, 0);
  endtask

  initial begin
    #(4 * 100000);
    if (!reported) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      reported = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_wave();
    t_invert();
    t_manual_full();
    t_oneshot();
    t_pause();
    t_last();
    if (!reported) begin
      reported = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
    $finish;
  end
endmodule